// File: doc/BRIEF.md
# Display Controller Register Bank with Set/Clear Aliases

This block holds the configuration registers of a display controller on a simple 32-bit register bus made of an address, write data, a write strobe and combinational read data. There are five registers: a main control word, a second control word, a packed transfer count, and a pair of frame-buffer address registers, one for the current buffer and one for the next. Every register occupies a 16-byte slot. Within the slot, three word addresses reach it. A write to the first overwrites the register. A write to the second ORs the data into it. A write to the third clears every bit that is 1 in the data. The set and clear forms let software change single bits without a read-modify-write cycle.

Two bits in the bank behave on their own schedule. The next-buffer address is staged, and it moves into the current-buffer register only on a frame-boundary pulse from the timing logic, so a buffer change never tears a frame. The run bit does not fall when software asks for a stop. A stop is requested by clearing the dot-clock mode bit, and the run bit then stays set until the pixel FIFO reports empty. The FIFO and the timing generator are outside the block, and each is represented by a single input. A soft-reset bit in the main control word holds the rest of the bank at its reset values.

Top module: `disp_ctrl_regs`

## Requirements
- R1: After an asynchronous active-low reset, all five registers read 0, and every field output is 0.
- R2: The register slots are at 0x00 (main control), 0x10 (second control), 0x20 (transfer count), 0x30 (current buffer) and 0x40 (next buffer). A write to a slot's base address replaces the whole register on the next clock edge.
- R3: A write to base+4 ORs the write data into the register.
- R4: A write to base+8 clears, in the register, every bit that is set in the write data.
- R5: A read of base, base+4 or base+8 returns the register value in the same cycle. Reads of base+0xC, of slots at 0x50 and above, and of addresses whose low two bits are not 0 all return 0, and writes to any of these addresses change nothing.
- R6: The fields of the main control word drive these outputs: run from bit 0, dot-clock mode from bit 17, clock gate from bit 30, bus width from bits 11:10, word length from bits 9:8, master from bit 5, and data-format flags from bits 3:1. In the second control word, FIFO clear is bit 21 and byte packing is bits 19:16. In the transfer count, the vertical count is bits 31:16 and the horizontal count is bits 15:0.
- R7: On a clock edge where the frame pulse is high, the current-buffer register takes the value the next-buffer register held before that edge.
- R8: A write to the next-buffer register leaves the current-buffer output unchanged until a frame pulse arrives.
- R9: A write sets the run bit from 0 to 1. While run is 1, a bus write that tries to clear the run bit is ignored.
- R10: While run is 1, it falls on the first clock edge at which the dot-clock mode bit is already 0 and the FIFO-empty input is 1. While either condition is missing, run stays 1.
- R11: While soft reset (main control bit 31) is 1, every other bit of the bank returns to 0 on the next edge and stays at 0, and writes to those bits are ignored. Bit 31 itself stays writable so that soft reset can be released.
- R12: If a frame pulse and a bus write to the current-buffer register fall on the same edge, the copy from the next-buffer register takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe |
| busRdata | output | 32 | Read data, combinational from address |
| frameTick | input | 1 | One-cycle frame-boundary pulse |
| fifoEmpty | input | 1 | Level flag: pixel FIFO holds no data |
| runActive | output | 1 | Run bit |
| dotClkMode | output | 1 | Dot-clock mode bit |
| clkGated | output | 1 | Clock gate bit |
| busWidth | output | 2 | Panel bus width field |
| wordLen | output | 2 | Input word length field |
| masterMode | output | 1 | Bus master bit |
| fmtFlags | output | 3 | Data-format flags, main control bits 3:1 |
| fifoClear | output | 1 | FIFO clear bit |
| bytePack | output | 4 | Byte packing field |
| vCount | output | 16 | Vertical transfer count |
| hCount | output | 16 | Horizontal transfer count |
| curBuf | output | 32 | Frame-buffer address in use |

## Verification
The bench sweeps every register through all three write forms with several data patterns. After each write it reads all three aliases and compares them against an arithmetic model. A decoder that swapped the set and clear forms, or that let the reserved fourth alias write, would show up as a wrong read-back. The stop sequence is tested in three steps: a bus attempt to clear run, then a cleared dot-clock bit with data still in the FIFO, then the FIFO going empty. A design that dropped run early, or one edge late, fails at the sampled cycle. The buffer tests check that a staged address never reaches the output before the frame pulse, and that the copy wins over a direct write on the same edge. Soft reset is checked by confirming that writes are discarded while it is held and that the bank works again after release.

// File: rtl/disp_reg_pkg.sv
package disp_reg_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_REGS  = 5;
  localparam int IDX_W     = $clog2(NUM_REGS);

  localparam int CTRL_IDX  = 0;
  localparam int CTRL2_IDX = 1;
  localparam int XFER_IDX  = 2;
  localparam int CUR_IDX   = 3;
  localparam int NEXT_IDX  = 4;

  localparam int RUN_BIT   = 0;
  localparam int DOT_BIT   = 17;
  localparam int GATE_BIT  = 30;
  localparam int SRST_BIT  = 31;
  localparam int FCLR_BIT  = 21;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } aliasOp_e;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    aliasOp_e         op;
    logic [REG_W-1:0] data;
    logic             rdHit;
    logic [IDX_W-1:0] rdIdx;
  } bankStrobe_t;

  function automatic logic [REG_W-1:0] applyOp(logic [REG_W-1:0] oldVal,
                                               logic [REG_W-1:0] wVal,
                                               aliasOp_e op);
    case (op)
      OP_PLAIN: applyOp = wVal;
      OP_SET:   applyOp = oldVal | wVal;
      OP_CLR:   applyOp = oldVal & ~wVal;
      default:  applyOp = oldVal;
    endcase
  endfunction
endpackage

// File: rtl/disp_reg_decode.sv
module disp_reg_decode
  import disp_reg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SLOT_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              busWe,
  output bankStrobe_t       stb
);
  localparam int SLOT_W = ADDR_W - SLOT_LOG2;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        aliasSel;
  logic              aligned;
  logic              slotHit;

  assign slot     = busAddr[ADDR_W-1:SLOT_LOG2];
  assign aliasSel = busAddr[3:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign slotHit  = aligned && (int'(slot) < NUM_REGS);

  always_comb begin
    stb.rdHit = slotHit && (aliasSel != 2'd3);
    stb.rdIdx = slot[IDX_W-1:0];
    stb.wrEn  = busWe && stb.rdHit;
    stb.wrIdx = slot[IDX_W-1:0];
    stb.op    = aliasOp_e'(aliasSel);
    stb.data  = busWdata;
  end
endmodule

// File: rtl/disp_reg_store.sv
module disp_reg_store
  import disp_reg_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  bankStrobe_t                      stb,
  input  logic                             frameTick,
  input  logic                             fifoEmpty,
  output logic [NUM_REGS-1:0][REG_W-1:0]   regOut,
  output logic [REG_W-1:0]                 rdData
);
  logic [REG_W-1:0] regQ   [NUM_REGS];
  logic [REG_W-1:0] regNxt [NUM_REGS];
  logic runQ, dotQ, srstQ, drainDone;

  assign runQ      = regQ[CTRL_IDX][RUN_BIT];
  assign dotQ      = regQ[CTRL_IDX][DOT_BIT];
  assign srstQ     = regQ[CTRL_IDX][SRST_BIT];
  assign drainDone = !dotQ && fifoEmpty;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      logic [REG_W-1:0] applied;
      applied = (stb.wrEn && int'(stb.wrIdx) == i)
                ? applyOp(regQ[i], stb.data, stb.op) : regQ[i];
      regNxt[i] = applied;
      if (i == CTRL_IDX) begin
        regNxt[i][RUN_BIT] = runQ ? !drainDone : applied[RUN_BIT];
      end
      if (i == CUR_IDX && frameTick) begin
        regNxt[i] = regQ[NEXT_IDX];
      end
      if (srstQ) begin
        regNxt[i] = '0;
        if (i == CTRL_IDX) regNxt[i][SRST_BIT] = applied[SRST_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= regNxt[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gOut
      assign regOut[g] = regQ[g];
    end
  endgenerate

  assign rdData = stb.rdHit ? regQ[stb.rdIdx] : '0;

  // R7: frame pulse copies the staged address
  a_r7_frame_copy: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && !srstQ) |=> (regQ[CUR_IDX] == $past(regQ[NEXT_IDX])));

  // R9: run stays up until the drain condition
  a_r9_run_hold: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !srstQ && !(!dotQ && fifoEmpty)) |=> runQ);

  // R10: run drops once dot-clock is off and the FIFO is empty
  a_r10_run_drain: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !dotQ && fifoEmpty) |=> !runQ);

  // R11: soft reset clears the rest of the bank
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    srstQ |=> (regQ[CTRL_IDX][30:0] == '0 && regQ[CTRL2_IDX] == '0 &&
               regQ[XFER_IDX] == '0 && regQ[CUR_IDX] == '0 &&
               regQ[NEXT_IDX] == '0));

  // R8: without a frame pulse or a write to it, the current buffer holds
  a_r8_cur_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!frameTick && !srstQ && !(stb.wrEn && int'(stb.wrIdx) == CUR_IDX))
      |=> $stable(regQ[CUR_IDX]));
endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import disp_reg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SLOT_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              busWe,
  output logic [REG_W-1:0]  busRdata,
  input  logic              frameTick,
  input  logic              fifoEmpty,
  output logic              runActive,
  output logic              dotClkMode,
  output logic              clkGated,
  output logic [1:0]        busWidth,
  output logic [1:0]        wordLen,
  output logic              masterMode,
  output logic [2:0]        fmtFlags,
  output logic              fifoClear,
  output logic [3:0]        bytePack,
  output logic [15:0]       vCount,
  output logic [15:0]       hCount,
  output logic [REG_W-1:0]  curBuf
);
  bankStrobe_t                    stb;
  logic [NUM_REGS-1:0][REG_W-1:0] regOut;
  logic [REG_W-1:0]               ctrlW, ctrl2W, xferW;

  disp_reg_decode #(.ADDR_W(ADDR_W), .SLOT_LOG2(SLOT_LOG2)) uDecode (
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busWe   (busWe),
    .stb     (stb)
  );

  disp_reg_store uStore (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .frameTick(frameTick),
    .fifoEmpty(fifoEmpty),
    .regOut   (regOut),
    .rdData   (busRdata)
  );

  assign ctrlW  = regOut[CTRL_IDX];
  assign ctrl2W = regOut[CTRL2_IDX];
  assign xferW  = regOut[XFER_IDX];

  assign runActive  = ctrlW[RUN_BIT];
  assign dotClkMode = ctrlW[DOT_BIT];
  assign clkGated   = ctrlW[GATE_BIT];
  assign busWidth   = ctrlW[11:10];
  assign wordLen    = ctrlW[9:8];
  assign masterMode = ctrlW[5];
  assign fmtFlags   = ctrlW[3:1];
  assign fifoClear  = ctrl2W[FCLR_BIT];
  assign bytePack   = ctrl2W[19:16];
  assign vCount     = xferW[31:16];
  assign hCount     = xferW[15:0];
  assign curBuf     = regOut[CUR_IDX];
endmodule

// File: tb/disp_ctrl_regs_test.sv
module disp_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic        frameTick = 1'b0;
  logic        fifoEmpty = 1'b0;
  logic        runActive, dotClkMode, clkGated, masterMode, fifoClear;
  logic [1:0]  busWidth, wordLen;
  logic [2:0]  fmtFlags;
  logic [3:0]  bytePack;
  logic [15:0] vCount, hCount;
  logic [31:0] curBuf;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [5];

  disp_ctrl_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .frameTick(frameTick),
    .fifoEmpty(fifoEmpty), .runActive(runActive), .dotClkMode(dotClkMode),
    .clkGated(clkGated), .busWidth(busWidth), .wordLen(wordLen),
    .masterMode(masterMode), .fmtFlags(fmtFlags), .fifoClear(fifoClear),
    .bytePack(bytePack), .vCount(vCount), .hCount(hCount), .curBuf(curBuf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] modelOp(logic [31:0] o, logic [31:0] d, int op);
    if (op == 0) return d;
    if (op == 1) return o | d;
    return o & ~d;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(2);
    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      rd(8'(r * 16), v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 reset run", {31'd0, runActive}, 32'd0);
    chk("R1 reset curBuf", curBuf, 32'd0);
    @(negedge clk); rstN = 1'b1;
    idle(1);
    for (int r = 0; r < 5; r++) begin
      rd(8'(r * 16), v);
      chk("R1 after release", v, 32'h0);
      model[r] = 32'h0;
    end

    // R2 R3 R4 R5 sweep over every register, alias and pattern
    for (int r = 0; r < 5; r++) begin
      for (int op = 0; op < 3; op++) begin
        for (int p = 0; p < 6; p++) begin
          logic [31:0] pat;
          pat = 32'h9E3779B9 * 32'(p + 1 + r * 8 + op * 40);
          if (p == 0) pat = 32'hFFFF_FFFF;
          if (p == 1) pat = 32'h0;
          if (r == 0) pat = pat & 32'h7FFF_FFFE;
          wr(8'(r * 16 + op * 4), pat);
          model[r] = modelOp(model[r], pat, op);
          for (int a = 0; a < 3; a++) begin
            rd(8'(r * 16 + a * 4), v);
            if (op == 0) chk("R2 plain write", v, model[r]);
            else if (op == 1) chk("R3 set alias", v, model[r]);
            else chk("R4 clear alias", v, model[r]);
          end
        end
      end
    end

    // R5 reserved and unmapped addresses
    wr(8'h10, 32'h1234_5678);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R5 reserved alias write ignored", v, 32'h1234_5678);
    rd(8'h1C, v); chk("R5 reserved alias reads 0", v, 32'h0);
    wr(8'h11, 32'h0);
    rd(8'h10, v); chk("R5 misaligned write ignored", v, 32'h1234_5678);
    rd(8'h12, v); chk("R5 misaligned read 0", v, 32'h0);
    wr(8'h50, 32'hDEAD_BEEF);
    rd(8'h50, v); chk("R5 unmapped read 0", v, 32'h0);
    for (int r = 0; r < 5; r++) begin
      rd(8'(r * 16), v);
      if (r != 1) chk("R5 unmapped write no effect", v, model[r]);
    end

    // R6 field positions
    wr(8'h00, 32'h4002_0B2A);
    wr(8'h10, 32'h0027_0000);
    wr(8'h20, 32'h0110_00F0);
    @(negedge clk);
    chk("R6 busWidth", {30'd0, busWidth}, 32'd2);
    chk("R6 wordLen", {30'd0, wordLen}, 32'd3);
    chk("R6 master", {31'd0, masterMode}, 32'd1);
    chk("R6 fmtFlags", {29'd0, fmtFlags}, 32'd5);
    chk("R6 dotClk", {31'd0, dotClkMode}, 32'd1);
    chk("R6 clkGate", {31'd0, clkGated}, 32'd1);
    chk("R6 run off", {31'd0, runActive}, 32'd0);
    chk("R6 fifoClear", {31'd0, fifoClear}, 32'd1);
    chk("R6 bytePack", {28'd0, bytePack}, 32'd7);
    chk("R6 vCount", {16'd0, vCount}, 32'h110);
    chk("R6 hCount", {16'd0, hCount}, 32'hF0);

    // R9 start and ignored bus clear
    wr(8'h04, 32'h1);
    chk("R9 run set", {31'd0, runActive}, 32'd1);
    wr(8'h08, 32'h1);
    chk("R9 bus clear ignored", {31'd0, runActive}, 32'd1);
    wr(8'h00, 32'h4002_0B2A);
    chk("R9 plain write zero ignored", {31'd0, runActive}, 32'd1);
    // R10 FIFO empty alone does not stop
    @(negedge clk); fifoEmpty = 1'b1;
    idle(2);
    chk("R10 dotclk still on", {31'd0, runActive}, 32'd1);
    @(negedge clk); fifoEmpty = 1'b0;
    wr(8'h08, 32'h0002_0000);
    chk("R10 dotclk cleared", {31'd0, dotClkMode}, 32'd0);
    idle(3);
    chk("R10 draining holds run", {31'd0, runActive}, 32'd1);
    fifoEmpty = 1'b1;
    @(negedge clk);
    chk("R10 run falls after empty", {31'd0, runActive}, 32'd0);
    fifoEmpty = 1'b0;
    rd(8'h00, v); chk("R10 control after drain", v, 32'h4000_0B2A);

    // R8 R7 buffer swap
    wr(8'h30, 32'h1111_0000);
    wr(8'h40, 32'hA5A5_0000);
    idle(3);
    chk("R8 staged not visible", curBuf, 32'h1111_0000);
    @(negedge clk); frameTick = 1'b1;
    @(negedge clk); frameTick = 1'b0;
    chk("R7 copied on frame", curBuf, 32'hA5A5_0000);
    wr(8'h44, 32'h0000_00C0);
    chk("R8 set alias staged", curBuf, 32'hA5A5_0000);
    // R12 copy beats direct write
    @(negedge clk);
    busAddr = 8'h30; busWdata = 32'h7777_7777; busWe = 1'b1; frameTick = 1'b1;
    @(negedge clk);
    busWe = 1'b0; frameTick = 1'b0;
    chk("R12 copy wins", curBuf, 32'hA5A5_00C0);

    // R11 soft reset
    wr(8'h04, 32'h8000_0000);
    @(negedge clk);
    for (int r = 0; r < 5; r++) begin
      rd(8'(r * 16), v);
      chk("R11 held at reset", v, (r == 0) ? 32'h8000_0000 : 32'h0);
    end
    wr(8'h10, 32'h00FF_00FF);
    rd(8'h10, v); chk("R11 write ignored", v, 32'h0);
    wr(8'h08, 32'h8000_0000);
    rd(8'h00, v); chk("R11 released", v, 32'h0);
    wr(8'h10, 32'h00FF_00FF);
    rd(8'h10, v); chk("R11 writable again", v, 32'h00FF_00FF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule